// File: doc/BRIEF.md
# Multicycle Shared-Memory Datapath

This block is the data half of a multicycle processor core for a small load/store instruction subset: word load, word store, register-register arithmetic and logic (add, subtract, and, or, signed set-less-than), branch-on-equal and jump. One unified word-addressed memory serves both instruction fetch and data access. A single ALU is reused across cycles to advance the PC, form the branch target, compute effective addresses and execute the operation. Values that must survive from one cycle to the next are held in internal registers: the instruction register, the memory data register, the two operand registers A and B, and the ALU output register.

The datapath makes no sequencing decisions of its own. Every multiplexer select and every write enable comes in on a plain control port that an external controller drives once per cycle. The block returns the opcode field of the instruction register and the ALU zero flag, which is what a controller needs to pick its next step. It also exposes the PC and the live ALU result so that its progress can be observed. A, B, the ALU output register and the memory data register load on every clock edge. Only the PC, the instruction register, the register file and the memory have enables. There is no streaming traffic at the edge, so all pins are plain level signals with no valid/ready handshake.

Top module: `mc_datapath`

## Requirements
- R1: While rst_n is low, the PC, the instruction register, the operand registers, the ALU output register, the memory data register and all registers of the register file are cleared, so pc_o and opcode_o read 0.
- R2: With ctl_iord=0 the memory is addressed by PC[7:2]. On an edge with ctl_ir_write=1 the instruction register takes the addressed word, and it holds its value otherwise. On an edge with ctl_pc_write=1 and ctl_pc_sel=00, the PC in the same edge takes the live ALU result, which is PC+4 when ctl_src_a=0 and ctl_src_b=01.
- R3: The first ALU operand is the PC when ctl_src_a=0 and register A when it is 1. The second operand is selected by ctl_src_b: 00 gives B, 01 gives the constant 4, 10 gives the sign-extended instruction bits [15:0], and 11 gives that value shifted left by two.
- R4: ctl_alu_op=00 forces an add and 01 forces a subtract. With 10 the function field, instruction bits [5:0], selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than, which gives 1 or 0.
- R5: With ctl_iord=1 the memory is addressed by the ALU output register. The addressed word enters the memory data register at the next edge. With ctl_reg_write=1, ctl_mem_to_reg=1 and ctl_reg_dst=0, that value is written to the register named by instruction bits [20:16].
- R6: On an edge with ctl_mem_write=1, the word at the current memory address is replaced by register B, and a later read of that address returns it.
- R7: With ctl_reg_write=1, ctl_reg_dst=1 and ctl_mem_to_reg=0, the ALU output register is written to the register named by instruction bits [15:11]. Register operands A and B are read from the registers named by bits [25:21] and [20:16].
- R8: With ctl_pc_sel=01 and ctl_pc_write_cond=1, the PC takes the ALU output register only when zero_o is 1. When zero_o is 0 and ctl_pc_write=0, the PC holds.
- R9: With ctl_pc_write=1 and ctl_pc_sel=10, the PC becomes {PC[31:28], instruction bits [25:0], 2'b00}.
- R10: Register 0 always reads as zero, and writes to it have no effect.
- R11: zero_o is 1 exactly when the live ALU result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_iord | input | 1 | Memory address source: 0 PC, 1 ALU output register |
| ctl_mem_write | input | 1 | Write register B into memory at this edge |
| ctl_ir_write | input | 1 | Load memory output into the instruction register |
| ctl_reg_dst | input | 1 | Destination register field: 0 bits [20:16], 1 bits [15:11] |
| ctl_mem_to_reg | input | 1 | Register write data: 0 ALU output register, 1 memory data register |
| ctl_reg_write | input | 1 | Write the register file at this edge |
| ctl_src_a | input | 1 | First ALU operand: 0 PC, 1 register A |
| ctl_src_b | input | 2 | Second ALU operand select (B, 4, immediate, immediate shifted by 2) |
| ctl_alu_op | input | 2 | 00 add, 01 subtract, 10 decode function field |
| ctl_pc_sel | input | 2 | Next PC: 00 live ALU, 01 ALU output register, 10 jump target |
| ctl_pc_write | input | 1 | Unconditional PC write |
| ctl_pc_write_cond | input | 1 | PC write qualified by the zero flag |
| opcode_o | output | 6 | Instruction register bits [31:26] |
| zero_o | output | 1 | Live ALU result is zero |
| pc_o | output | 32 | Current PC |
| alu_result_o | output | 32 | Live ALU result |

## Verification
The fetch cycle is the point where two of the block's functions share one edge. The PC is overwritten by the live ALU sum, while the instruction register captures the memory word that the old PC addresses. If the memory address follows the PC too early, a wrong instruction is loaded. The bench runs a preloaded program through its fetch, decode and execute steps and judges that edge at the next decode cycle: opcode_o must be the opcode of the word at the old PC, and pc_o must be the old PC plus four. A second overlap is checked on every branch. In the branch cycle the PC write depends on the zero flag, which is produced in that same cycle by the subtraction. One taken and one untaken branch are run, and the PC is compared with the target formed during decode and with the fall-through address.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int NREGS  = 1 << REG_AW;

  localparam logic [1:0] SRCB_REG    = 2'b00;
  localparam logic [1:0] SRCB_FOUR   = 2'b01;
  localparam logic [1:0] SRCB_IMM    = 2'b10;
  localparam logic [1:0] SRCB_IMM_SH = 2'b11;

  localparam logic [1:0] PCSEL_ALU    = 2'b00;
  localparam logic [1:0] PCSEL_ALUOUT = 2'b01;
  localparam logic [1:0] PCSEL_JUMP   = 2'b10;

  localparam logic [1:0] AOP_ADD   = 2'b00;
  localparam logic [1:0] AOP_SUB   = 2'b01;
  localparam logic [1:0] AOP_FUNCT = 2'b10;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_fn_e;
endpackage

// File: rtl/mcd_alu.sv
module mcd_alu
  import mcd_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [1:0]      alu_op,
  input  logic [5:0]      funct,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  alu_fn_e fn;

  // operation select: forced add/sub, or decoded from the function field
  always_comb begin
    fn = ALU_ADD;
    if (alu_op == AOP_SUB) begin
      fn = ALU_SUB;
    end else if (alu_op == AOP_FUNCT) begin
      case (funct)
        FN_ADD:  fn = ALU_ADD;
        FN_SUB:  fn = ALU_SUB;
        FN_AND:  fn = ALU_AND;
        FN_OR:   fn = ALU_OR;
        FN_SLT:  fn = ALU_SLT;
        default: fn = ALU_ADD;
      endcase
    end
  end

  always_comb begin
    case (fn)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mcd_regfile.sv
module mcd_regfile
  import mcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] ra1,
  input  logic [REG_AW-1:0] ra2,
  input  logic [REG_AW-1:0] wa,
  input  logic              we,
  input  logic [XLEN-1:0]   wd,
  output logic [XLEN-1:0]   rd1,
  output logic [XLEN-1:0]   rd2
);
  logic [XLEN-1:0] rf_view [NREGS];

  assign rf_view[0] = '0;

  for (genvar g = 1; g < NREGS; g++) begin : g_reg
    logic [XLEN-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                               q <= '0;
      else if (we && (wa == REG_AW'(g)))        q <= wd;
    end
    assign rf_view[g] = q;
  end

  assign rd1 = rf_view[ra1];
  assign rd2 = rf_view[ra2];

  AST_RF_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (we && wa != '0) |=> (rf_view[$past(wa)] == $past(wd))); // R7
  AST_R0_STAYS: assert property (@(posedge clk) disable iff (!rst_n) (we && wa == '0) |=> (rf_view[0] == '0)); // R10
endmodule

// File: rtl/mcd_mem.sv
module mcd_mem
  import mcd_pkg::*;
#(
  parameter int WORDS = 64,
  localparam int AW = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   idx,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata
);
  logic [XLEN-1:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem_q[idx] <= wdata;
  end

  assign rdata = mem_q[idx];

  AST_MEM_STORE: assert property (@(posedge clk) disable iff (!rst_n) we |=> (mem_q[$past(idx)] == $past(wdata))); // R6
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mcd_pkg::*;
#(
  parameter int MEM_WORDS = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_iord,
  input  logic            ctl_mem_write,
  input  logic            ctl_ir_write,
  input  logic            ctl_reg_dst,
  input  logic            ctl_mem_to_reg,
  input  logic            ctl_reg_write,
  input  logic            ctl_src_a,
  input  logic [1:0]      ctl_src_b,
  input  logic [1:0]      ctl_alu_op,
  input  logic [1:0]      ctl_pc_sel,
  input  logic            ctl_pc_write,
  input  logic            ctl_pc_write_cond,
  output logic [5:0]      opcode_o,
  output logic            zero_o,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] alu_result_o
);
  localparam int MEM_AW = $clog2(MEM_WORDS);

  logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
  logic [XLEN-1:0] alu_a, alu_b, alu_y, imm_ext, pc_next;
  logic [XLEN-1:0] rf_rd1, rf_rd2, rf_wd, mem_rdata;
  logic [REG_AW-1:0] rf_wa;
  logic [MEM_AW-1:0] mem_idx;
  logic alu_zero, pc_en;

  // shared memory: PC for fetch, ALU output register for data
  assign mem_idx = ctl_iord ? aluout_q[MEM_AW+1:2] : pc_q[MEM_AW+1:2];

  mcd_mem #(.WORDS(MEM_WORDS)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctl_mem_write),
    .idx   (mem_idx),
    .wdata (b_q),
    .rdata (mem_rdata)
  );

  assign rf_wa = ctl_reg_dst ? ir_q[15:11] : ir_q[20:16];
  assign rf_wd = ctl_mem_to_reg ? mdr_q : aluout_q;

  mcd_regfile u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra1   (ir_q[25:21]),
    .ra2   (ir_q[20:16]),
    .wa    (rf_wa),
    .we    (ctl_reg_write),
    .wd    (rf_wd),
    .rd1   (rf_rd1),
    .rd2   (rf_rd2)
  );

  assign imm_ext = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
  assign alu_a   = ctl_src_a ? a_q : pc_q;

  always_comb begin
    case (ctl_src_b)
      SRCB_REG:    alu_b = b_q;
      SRCB_FOUR:   alu_b = XLEN'(4);
      SRCB_IMM:    alu_b = imm_ext;
      default:     alu_b = {imm_ext[XLEN-3:0], 2'b00};
    endcase
  end

  mcd_alu u_alu (
    .a      (alu_a),
    .b      (alu_b),
    .alu_op (ctl_alu_op),
    .funct  (ir_q[5:0]),
    .y      (alu_y),
    .zero   (alu_zero)
  );

  always_comb begin
    case (ctl_pc_sel)
      PCSEL_ALUOUT: pc_next = aluout_q;
      PCSEL_JUMP:   pc_next = {pc_q[XLEN-1:XLEN-4], ir_q[25:0], 2'b00};
      default:      pc_next = alu_y;
    endcase
  end

  assign pc_en = ctl_pc_write | (ctl_pc_write_cond & alu_zero);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= '0;
      ir_q     <= '0;
      mdr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
    end else begin
      if (pc_en)        pc_q <= pc_next;
      if (ctl_ir_write) ir_q <= mem_rdata;
      mdr_q    <= mem_rdata;
      a_q      <= rf_rd1;
      b_q      <= rf_rd2;
      aluout_q <= alu_y;
    end
  end

  assign opcode_o     = ir_q[31:26];
  assign zero_o       = alu_zero;
  assign pc_o         = pc_q;
  assign alu_result_o = alu_y;

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !ctl_ir_write |=> $stable(ir_q)); // R2
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!ctl_pc_write && !(ctl_pc_write_cond && zero_o)) |=> $stable(pc_o)); // R8
  AST_BR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (!ctl_pc_write && ctl_pc_write_cond && zero_o && ctl_pc_sel == PCSEL_ALUOUT) |=> (pc_o == $past(aluout_q))); // R8
  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_n) (ctl_pc_write && ctl_pc_sel == PCSEL_JUMP) |=> (pc_o[1:0] == 2'b00 && pc_o[XLEN-1:XLEN-4] == $past(pc_o[XLEN-1:XLEN-4]))); // R9
endmodule

// File: tb/mc_datapath_tb_top.sv
module mc_datapath_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        c_iord, c_mw, c_irw, c_rdst, c_m2r, c_rw, c_sa, c_pcw, c_pcwc;
  logic [1:0]  c_sb, c_aop, c_psel;
  logic [5:0]  opcode_o;
  logic        zero_o;
  logic [31:0] pc_o, alu_result_o;

  always #5 clk = ~clk;

  mc_datapath dut_i (
    .clk(clk), .rst_n(rst_n),
    .ctl_iord(c_iord), .ctl_mem_write(c_mw), .ctl_ir_write(c_irw),
    .ctl_reg_dst(c_rdst), .ctl_mem_to_reg(c_m2r), .ctl_reg_write(c_rw),
    .ctl_src_a(c_sa), .ctl_src_b(c_sb), .ctl_alu_op(c_aop),
    .ctl_pc_sel(c_psel), .ctl_pc_write(c_pcw), .ctl_pc_write_cond(c_pcwc),
    .opcode_o(opcode_o), .zero_o(zero_o), .pc_o(pc_o), .alu_result_o(alu_result_o)
  );

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    finished = 0;

  // monitor: pops expectations and compares them with the ports
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        string nm;
        it = q.pop_front();
        case (it.sel)
          0: begin act = pc_o;                 nm = "pc";     end
          1: begin act = alu_result_o;         nm = "alu";    end
          2: begin act = {26'd0, opcode_o};    nm = "opcode"; end
          default: begin act = {31'd0, zero_o}; nm = "zero";  end
        endcase
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s %s: actual %h expected %h", it.tag, nm, act, it.exp);
        end
      end
    end
  end

  task automatic expect_v(input int sel, input logic [31:0] exp, input string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
    -> chk_ev;
  endtask

  task automatic idle_ctl();
    c_iord = 0; c_mw = 0; c_irw = 0; c_rdst = 0; c_m2r = 0; c_rw = 0;
    c_sa = 0; c_pcw = 0; c_pcwc = 0; c_sb = 2'b00; c_aop = 2'b00; c_psel = 2'b00;
  endtask

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction

  logic [31:0] pc_m;  // bench model of the PC

  task automatic st_fetch();
    @(negedge clk); idle_ctl();
    c_irw = 1; c_sb = 2'b01; c_pcw = 1; #1;
    expect_v(1, pc_m + 32'd4, "R2 fetch increment");
  endtask

  task automatic st_decode(input logic [5:0] op, input logic [31:0] tgt, input bit chk_tgt);
    @(negedge clk); idle_ctl();
    c_sb = 2'b11; #1;
    pc_m = pc_m + 32'd4;
    expect_v(0, pc_m, "R2 pc after fetch");
    expect_v(2, {26'd0, op}, "R2 opcode fetched");
    if (chk_tgt) expect_v(1, tgt, "R3 branch target");
  endtask

  task automatic run_lw(input logic [31:0] ea);
    st_fetch(); st_decode(6'd35, 0, 0);
    @(negedge clk); idle_ctl(); c_sa = 1; c_sb = 2'b10; #1;
    expect_v(1, ea, "R3 immediate address");
    @(negedge clk); idle_ctl(); c_iord = 1; #1;
    @(negedge clk); idle_ctl(); c_rw = 1; c_m2r = 1; #1;
  endtask

  task automatic run_sw(input logic [31:0] ea);
    st_fetch(); st_decode(6'd43, 0, 0);
    @(negedge clk); idle_ctl(); c_sa = 1; c_sb = 2'b10; #1;
    expect_v(1, ea, "R3 store address");
    @(negedge clk); idle_ctl(); c_iord = 1; c_mw = 1; #1;
  endtask

  task automatic run_r(input logic [31:0] res, input string tag);
    st_fetch(); st_decode(6'd0, 0, 0);
    @(negedge clk); idle_ctl(); c_sa = 1; c_aop = 2'b10; #1;
    expect_v(1, res, tag);
    expect_v(3, {31'd0, res == 32'd0}, "R11 zero flag");
    @(negedge clk); idle_ctl(); c_rw = 1; c_rdst = 1; #1;
  endtask

  task automatic run_beq(input logic [31:0] tgt, input logic [31:0] diff, input bit taken);
    st_fetch(); st_decode(6'd4, tgt, 1);
    @(negedge clk); idle_ctl(); c_sa = 1; c_aop = 2'b01; c_pcwc = 1; c_psel = 2'b01; #1;
    expect_v(1, diff, "R4 forced subtract");
    expect_v(3, {31'd0, taken}, "R11 zero on compare");
    if (taken) pc_m = tgt;
  endtask

  localparam logic [31:0] D8 = 32'h1234_5678;
  localparam logic [31:0] D9 = 32'hFFFF_FFF0;

  initial begin
    for (int i = 0; i < 64; i++) dut_i.u_mem.mem_q[i] = 32'd0;
    dut_i.u_mem.mem_q[0]  = enc_i(6'd35, 5'd0, 5'd8,  16'h00C0);
    dut_i.u_mem.mem_q[1]  = enc_i(6'd35, 5'd0, 5'd9,  16'h00C4);
    dut_i.u_mem.mem_q[2]  = enc_r(5'd8, 5'd9, 5'd10, 6'h20);
    dut_i.u_mem.mem_q[3]  = enc_r(5'd8, 5'd9, 5'd11, 6'h22);
    dut_i.u_mem.mem_q[4]  = enc_r(5'd8, 5'd9, 5'd12, 6'h24);
    dut_i.u_mem.mem_q[5]  = enc_r(5'd8, 5'd9, 5'd13, 6'h25);
    dut_i.u_mem.mem_q[6]  = enc_r(5'd9, 5'd8, 5'd14, 6'h2A);
    dut_i.u_mem.mem_q[7]  = enc_r(5'd8, 5'd9, 5'd15, 6'h2A);
    dut_i.u_mem.mem_q[8]  = enc_i(6'd43, 5'd0, 5'd10, 16'h00C8);
    dut_i.u_mem.mem_q[9]  = enc_i(6'd35, 5'd0, 5'd16, 16'h00C8);
    dut_i.u_mem.mem_q[10] = enc_r(5'd16, 5'd0, 5'd17, 6'h20);
    dut_i.u_mem.mem_q[11] = enc_r(5'd8, 5'd9, 5'd0, 6'h20);
    dut_i.u_mem.mem_q[12] = enc_r(5'd0, 5'd0, 5'd18, 6'h20);
    dut_i.u_mem.mem_q[13] = enc_r(5'd10, 5'd11, 5'd19, 6'h22);
    dut_i.u_mem.mem_q[14] = enc_i(6'd4, 5'd8, 5'd8, 16'd2);
    dut_i.u_mem.mem_q[17] = enc_i(6'd4, 5'd8, 5'd9, 16'd3);
    dut_i.u_mem.mem_q[18] = {6'd2, 26'h20};
    dut_i.u_mem.mem_q[48] = D8;
    dut_i.u_mem.mem_q[49] = D9;

    idle_ctl();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    expect_v(0, 32'd0, "R1 reset pc");
    expect_v(2, 32'd0, "R1 reset opcode");
    expect_v(1, 32'd0, "R1 reset alu");
    expect_v(3, 32'd1, "R11 zero at reset");
    rst_n = 1;
    pc_m = 32'd0;

    run_lw(32'h00C0);                               // R5
    run_lw(32'h00C4);
    run_r(D8 + D9, "R4 add funct");                 // also R5 load values
    run_r(D8 - D9, "R4 sub funct");
    run_r(D8 & D9, "R4 and funct");
    run_r(D8 | D9, "R4 or funct");
    run_r(32'd1, "R4 signed slt true");
    run_r(32'd0, "R4 signed slt false");
    run_sw(32'h00C8);                               // R6
    run_lw(32'h00C8);
    run_r(D8 + D9, "R6 stored word reloaded R5");
    run_r(D8 + D9, "R10 write to r0 executes");
    run_r(32'd0, "R10 r0 reads zero");
    run_r((D8 + D9) - (D8 - D9), "R7 rd writeback");
    run_beq(32'd68, 32'd0, 1);                      // taken, R8
    st_fetch();                                     // fetch at 68
    st_decode(6'd4, 32'd84, 1);
    pc_m = pc_m - 32'd4;                            // undo: decode checked pc for 68
    // complete the untaken branch
    @(negedge clk); idle_ctl(); c_sa = 1; c_aop = 2'b01; c_pcwc = 1; c_psel = 2'b01; #1;
    expect_v(1, D8 - D9, "R8 untaken compare");
    expect_v(3, 32'd0, "R8 untaken zero");
    pc_m = pc_m + 32'd4;
    @(negedge clk); idle_ctl(); #1;
    expect_v(0, pc_m, "R8 pc holds on untaken");
    // jump at 72
    st_fetch(); st_decode(6'd2, 0, 0);
    @(negedge clk); idle_ctl(); c_pcw = 1; c_psel = 2'b10; #1;
    @(negedge clk); idle_ctl(); #1;
    expect_v(0, 32'h0000_0080, "R9 jump target");
    @(negedge clk); idle_ctl(); c_sb = 2'b01; #1;
    expect_v(1, 32'h0000_0084, "R3 constant four");
    #2;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule